// File: doc/BRIEF.md
# Fall-Through Stack Array

This block is a self-timed word stack that behaves as a first-in first-out queue with no read or write pointers. Every location keeps one data word and one occupancy flag. A word enters at the top location and, on every clock, drops one location lower whenever the location beneath it is free. Words therefore settle at the bottom in arrival order. The bottom location offers its word to a downstream output stage and gives it up when that stage pops it.

The upstream input stage pushes through a valid/ready pair at the top. The downstream output stage pops through a valid/ready pair at the bottom. The depth and the word width are parameters, with defaults of 14 locations of 4 bits. A reset clears only the occupancy flags. The stored data bits keep their values through a reset.

Top module: `fts_stack`

## Requirements
- R1: After reset, `out_vld` is 0 and `in_rdy` is 1.
- R2: `in_rdy` is 1 exactly when the top location is free. A push is a cycle with `in_vld` and `in_rdy` both high. A push attempt while `in_rdy` is 0 stores nothing.
- R3: A word pushed into an empty stack moves down one location per clock. `out_vld` rises DEPTH-1 clock edges after the edge that accepted the push.
- R4: A word stops while the location below it is occupied. With no pops, the stack holds exactly DEPTH words and `in_rdy` then stays 0.
- R5: While `out_vld` is 1 and `out_rdy` is 0, `out_data` and `out_vld` hold steady. A pop is a cycle with `out_vld` and `out_rdy` both high. A pop removes the bottom word.
- R6: When a full stack is popped once, the freed slot rises one location per clock. `in_rdy` returns to 1 DEPTH-1 clock edges after the pop edge.
- R7: Words leave in the order they were pushed, with none lost or duplicated. This holds when a push and a pop occur in the same cycle.
- R8: Reset clears every occupancy flag but leaves the stored data. `out_data` keeps showing the former bottom word after reset.
- R9: In the cycle after a push is accepted, `in_rdy` is 0, because the top location is now occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the occupancy flags |
| in_vld | input | 1 | Upstream offers a word |
| in_rdy | output | 1 | Top location is free |
| in_data | input | WIDTH | Word offered for push |
| out_vld | output | 1 | Bottom location holds a word |
| out_rdy | input | 1 | Downstream takes the bottom word |
| out_data | output | WIDTH | Word held in the bottom location |

## Verification
A push at the top and a pop at the bottom can fall in the same cycle. They touch opposite ends of the chain, while words in the middle are still moving. The bench provokes this by driving `in_vld` and `out_rdy` from a pseudo-random sequence at several duty ratios. It checks that such coincident cycles actually occur. Every popped word is compared with a queue model, so any loss, duplication or reordering shows up as a mismatch. The full and empty extremes are checked with exact cycle counts for fall-through and bubble-up.

// File: rtl/fts_pkg.sv
// Package: shared defaults for the fall-through stack.
// Assumes: nothing beyond parameter defaults.
package fts_pkg;
    parameter int FTS_WIDTH = 4;
    parameter int FTS_DEPTH = 14;
endpackage

// File: rtl/fts_cell.sv
// Module: fts_cell
// One stack location: a data word and an occupancy flag.
// Assumes: take is asserted only while the location is free, and
// give is asserted only while it is occupied. Data is never reset.
module fts_cell #(
    parameter int WIDTH = fts_pkg::FTS_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             give,
    input  logic [WIDTH-1:0] d_in,
    output logic             vld,
    output logic [WIDTH-1:0] dat
);
    // Occupancy flag: set on take, cleared on give, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld <= 1'b0;
        else if (take)
            vld <= 1'b1;
        else if (give)
            vld <= 1'b0;
    end

    // Data word: loaded on take and never reset.
    always_ff @(posedge clk) begin
        if (take)
            dat <= d_in;
    end

    AST_TAKE_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !vld); // R4
    AST_GIVE_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        give |-> vld); // R7
endmodule

// File: rtl/fts_move_ctl.sv
// Module: fts_move_ctl
// Decides from the current occupancy vector which locations load and
// which release this cycle. Index 0 is the bottom, DEPTH-1 the top.
// Assumes: DEPTH >= 2. Every move is computed in parallel from
// current state only.
module fts_move_ctl #(
    parameter int DEPTH = fts_pkg::FTS_DEPTH
) (
    input  logic [DEPTH-1:0] vld,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [DEPTH-1:0] take,
    output logic [DEPTH-1:0] give
);
    localparam int TOP = DEPTH - 1;

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_loc
            if (i == TOP) begin : g_top
                // Top loads a pushed word only when it is free.
                always_comb take[i] = push_req && !vld[i];
            end else begin : g_mid
                // Lower location loads from above when it is free and above is held.
                always_comb take[i] = !vld[i] && vld[i+1];
            end
            if (i == 0) begin : g_bot
                // Bottom releases on a pop.
                always_comb give[i] = pop_req && vld[i];
            end else begin : g_up
                // Upper location releases when the one below takes its word.
                always_comb give[i] = take[i-1];
            end
        end
    endgenerate
endmodule

// File: rtl/fts_stack.sv
// Module: fts_stack
// Self-timed fall-through FIFO core. Words enter at the top and drop
// one location per clock toward the bottom while space allows.
// Assumes: synchronous active-low reset, which clears occupancy only.
module fts_stack #(
    parameter int WIDTH = fts_pkg::FTS_WIDTH,
    parameter int DEPTH = fts_pkg::FTS_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    output logic             in_rdy,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_vld,
    input  logic             out_rdy,
    output logic [WIDTH-1:0] out_data
);
    localparam int TOP = DEPTH - 1;

    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] take;
    logic [DEPTH-1:0] give;
    logic [WIDTH-1:0] dat [DEPTH];
    logic             past_ok;

    fts_move_ctl #(.DEPTH(DEPTH)) u_ctl (
        .vld      (vld),
        .push_req (in_vld),
        .pop_req  (out_rdy),
        .take     (take),
        .give     (give)
    );

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_cell
            logic [WIDTH-1:0] src;
            if (i == TOP) begin : g_src_in
                // Top location is fed from the push port.
                always_comb src = in_data;
            end else begin : g_src_up
                // Other locations are fed from the location above.
                always_comb src = dat[i+1];
            end
            fts_cell #(.WIDTH(WIDTH)) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .take  (take[i]),
                .give  (give[i]),
                .d_in  (src),
                .vld   (vld[i]),
                .dat   (dat[i])
            );
        end
    endgenerate

    // Port view of the top and bottom locations.
    always_comb begin
        in_rdy   = !vld[TOP];
        out_vld  = vld[0];
        out_data = dat[0];
    end

    // Marks cycles whose previous cycle was out of reset, so $past is meaningful.
    always_ff @(posedge clk) begin
        past_ok <= rst_n;
    end

    AST_COUNT_KEPT: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $countones(vld) == $past($countones(vld))
                           + int'($past(in_vld && in_rdy))
                           - int'($past(out_vld && out_rdy))); // R7
    AST_BOTTOM_HELD: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_data))); // R5
    AST_TOP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (in_vld && in_rdy) |=> !in_rdy); // R9
    AST_NO_BLIND_PUSH: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!in_rdy && !$past(in_rdy)) |-> $countones(vld) <= $past($countones(vld))); // R2
endmodule

// File: tb/sim_fts_stack.sv
module sim_fts_stack;
    localparam int W = 4;
    localparam int D = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld = 1'b0;
    logic         in_rdy;
    logic [W-1:0] in_data = '0;
    logic         out_vld;
    logic         out_rdy = 1'b0;
    logic [W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int n_both = 0;
    bit done = 1'b0;
    logic [W-1:0] mq [$];

    always #2 clk = ~clk;

    fts_stack #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_rdy(in_rdy),
        .in_data(in_data), .out_vld(out_vld), .out_rdy(out_rdy),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: track handshakes in the model, compare popped words.
    task automatic step();
        bit pu, po;
        logic [W-1:0] pd, od;
        pu = in_vld && in_rdy && rst_n;
        po = out_vld && out_rdy && rst_n;
        pd = in_data;
        od = out_data;
        if (pu && po) n_both++;
        if (po) begin
            if (mq.size() == 0) chk(1'b0, "R7 pop from empty model", 1, 0);
            else begin
                chk(od == mq[0], "R7 order", int'(od), int'(mq[0]));
                void'(mq.pop_front());
            end
        end
        if (pu) mq.push_back(pd);
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int n;
        logic [15:0] lf;
        logic [W-1:0] held;
        @(posedge clk); #1;
        step(); step();
        rst_n = 1'b1;
        step();
        chk(out_vld == 1'b0, "R1 out_vld", int'(out_vld), 0);
        chk(in_rdy == 1'b1, "R1 in_rdy", int'(in_rdy), 1);

        // R3 fall-through latency, R9 top occupied
        in_vld = 1'b1; in_data = 4'hA;
        step();
        in_vld = 1'b0;
        chk(in_rdy == 1'b0, "R9 in_rdy after push", int'(in_rdy), 0);
        n = 0;
        while (!out_vld && n < 100) begin step(); n++; end
        chk(n == D - 1, "R3 fall-through cycles", n, D - 1);
        chk(out_data == 4'hA, "R3 data", int'(out_data), 10);

        // R5 hold while not popped, then pop
        held = out_data;
        for (int k = 0; k < 5; k++) begin
            step();
            chk(out_vld && out_data == held, "R5 hold", int'(out_data), int'(held));
        end
        out_rdy = 1'b1;
        step();
        out_rdy = 1'b0;
        chk(out_vld == 1'b0, "R5 pop empties", int'(out_vld), 0);

        // R4 capacity with continuous push attempts, R2 refused pushes
        n = 0;
        in_vld = 1'b1;
        for (int k = 0; k < 120; k++) begin
            in_data = W'(n + 1);
            if (in_rdy) n++;
            step();
        end
        in_vld = 1'b0;
        chk(n == D, "R4 capacity", n, D);
        chk(in_rdy == 1'b0, "R4 full in_rdy", int'(in_rdy), 0);
        chk(mq.size() == D, "R2 stored count", mq.size(), D);

        // R6 bubble-up latency
        out_rdy = 1'b1;
        step();
        out_rdy = 1'b0;
        n = 0;
        while (!in_rdy && n < 100) begin step(); n++; end
        chk(n == D - 1, "R6 bubble-up cycles", n, D - 1);

        // drain and confirm count
        out_rdy = 1'b1;
        for (int k = 0; k < 60; k++) step();
        out_rdy = 1'b0;
        chk(mq.size() == 0 && !out_vld, "R2 drained", mq.size(), 0);

        // R7 sweep over push and pop duty ratios
        lf = 16'hACE1;
        for (int pr = 1; pr < 4; pr++) begin
            for (int qr = 1; qr < 4; qr++) begin
                for (int k = 0; k < 1500; k++) begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    in_vld  = (int'(lf[1:0]) < pr);
                    out_rdy = (int'(lf[5:4]) < qr);
                    in_data = lf[11:8];
                    step();
                end
            end
        end
        in_vld = 1'b0; out_rdy = 1'b1;
        for (int k = 0; k < 60; k++) step();
        out_rdy = 1'b0;
        chk(mq.size() == 0, "R7 nothing lost", mq.size(), 0);
        chk(n_both > 0, "R7 coincident push and pop seen", n_both, 1);

        // R8 reset keeps data
        in_vld = 1'b1; in_data = 4'h5;
        step();
        in_data = 4'hC;
        while (!in_rdy) step();
        step();
        in_vld = 1'b0;
        while (!out_vld) step();
        held = out_data;
        chk(held == 4'h5, "R8 bottom word", int'(held), 5);
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        mq.delete();
        step();
        chk(out_vld == 1'b0, "R8 out_vld cleared", int'(out_vld), 0);
        chk(in_rdy == 1'b1, "R8 in_rdy", int'(in_rdy), 1);
        chk(out_data == 4'h5, "R8 data kept", int'(out_data), 5);
        in_vld = 1'b1; in_data = 4'h3;
        step();
        in_vld = 1'b0;
        n = 0;
        while (!out_vld && n < 100) begin step(); n++; end
        chk(out_data == 4'h3 && n == D - 1, "R8 works after reset", int'(out_data), 3);
        out_rdy = 1'b1;
        step();
        out_rdy = 1'b0;
        finish_run();
    end
endmodule